// File: doc/BRIEF.md
# Trimmed Seconds Prescaler

This block is the first stage of a real-time clock. A count enable, normally pulsing at 32.768 kHz, advances an internal counter. Each time the counter reaches its carry point the block emits a one-cycle second tick and advances a BCD seconds register that runs from 00 to 59. When the register wraps to 00, the block also emits a minute-carry pulse for the next stage.

Crystal error is trimmed digitally. An 8-bit trim register, written through a strobe and a data byte, holds three fields: a mode bit, a sign bit and a 6-bit magnitude. The selected step is always even. On the eligible seconds, which are every 20th second or every 60th second depending on the mode, the step either shortens or lengthens that one second by the given number of counts.

The trim value is captured at the start of each eligible second, so a write made part way through a second does not change that second. Writes are refused during the seconds in which a trim could be taken. A refused write sets a sticky error flag, and a read strobe clears it.

Top module: `rtc_sec_trim`

## Requirements
- R1: After reset, the seconds output is 00h, the trim register reads 00h, and the tick, minute-carry and write-error outputs are all low.
- R2: With no trim active, a second lasts SEC_TOP+1 asserted count enables (32768 by default). The tick is a single-cycle pulse that can follow only an edge on which the count enable was high.
- R3: The seconds output counts in BCD from 00h to 59h and changes only on the tick cycle. On the tick that takes 59h to 00h, the minute carry is high for that same single cycle, and it is high at no other time.
- R4: Trim register fields: bit 7 is the mode, bit 6 is the sign, and bits 5:0 are the magnitude F. An accepted write replaces the whole byte, and the register reads back as written.
- R5: With mode 0, trim applies to the seconds whose BCD value is 00h, 20h or 40h. With mode 1, it applies only to second 00h.
- R6: With the sign bit at 0, a trimmed second is shorter by (F-1)*2 enables, from 2 to 124. The counter starts that second advanced by this amount.
- R7: With the sign bit at 1, a trimmed second is longer by ((~F)+1)*2 enables, with ~F taken over 6 bits, from 2 to 124.
- R8: When F[5:1] is zero, no trim is applied, whatever the values of the sign bit and F[0].
- R9: A write that arrives while the seconds value is one of the trim seconds of the current mode is ignored and sets the write-error flag. At any other time the write is accepted.
- R10: A read strobe clears the write-error flag on the next edge. A refused write in the same cycle takes priority and keeps the flag set.
- R11: The trim for a second is fixed from the register contents at the tick that begins it. A write during that second does not change its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cnt_en_i | input | 1 | Sub-clock count enable |
| wr_en_i | input | 1 | Trim register write strobe |
| wr_data_i | input | 8 | Trim register write data |
| rd_err_i | input | 1 | Read strobe for the write-error flag (clears it) |
| sec_bcd_o | output | 8 | BCD seconds, 00h to 59h |
| sec_tick_o | output | 1 | One-cycle pulse per second |
| min_carry_o | output | 1 | One-cycle pulse on the 59-to-00 wrap |
| trim_reg_o | output | 8 | Trim register readback |
| wr_err_o | output | 1 | Sticky write-error flag |

## Verification
The bench builds the block with CNT_W = 9 and SEC_TOP = 199. A nominal second is therefore 200 enables, and the largest lengthened second, 324 enables, still fits in the counter. With a second this short, more than three full minutes run within the cycle budget, so every 59-to-00 carry and every trim second in both modes comes up several times. The extreme steps of +124 and -124 and an enable that is high only on every other cycle are also reached. Second lengths are counted in asserted enables rather than in clock cycles, so the same expected lengths hold under either enable pattern.

// File: rtl/rtc_trim_pkg.sv
package rtc_trim_pkg;

  typedef struct packed {
    logic       mode;  // 1: trim only at second 00
    logic       neg;   // 1: lengthen the second
    logic [5:0] mag;
  } trim_t;

  function automatic logic is_trim_sec(input logic mode, input logic [7:0] bcd);
    if (mode) return bcd == 8'h00;
    return (bcd == 8'h00) || (bcd == 8'h20) || (bcd == 8'h40);
  endfunction

  function automatic logic [7:0] bcd_next(input logic [7:0] bcd);
    if (bcd == 8'h59)       return 8'h00;
    if (bcd[3:0] == 4'd9)   return {bcd[7:4] + 4'd1, 4'd0};
    return {bcd[7:4], bcd[3:0] + 4'd1};
  endfunction

endpackage

// File: rtl/rtc_trim_reg.sv
module rtc_trim_reg
  import rtc_trim_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  input  logic       rd_err_i,
  input  logic [7:0] sec_bcd_i,
  output trim_t      trim_o,
  output logic       err_o
);

  trim_t trim_q;
  logic  err_q;
  logic  blocked;

  assign blocked = wr_en_i && is_trim_sec(trim_q.mode, sec_bcd_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trim_q <= '0;
      err_q  <= 1'b0;
    end else begin
      if (wr_en_i && !blocked) trim_q <= trim_t'(wr_data_i);
      // refused write wins over a clearing read
      if (blocked)       err_q <= 1'b1;
      else if (rd_err_i) err_q <= 1'b0;
    end
  end

  assign trim_o = trim_q;
  assign err_o  = err_q;

endmodule

// File: rtl/rtc_trim_step.sv
module rtc_trim_step
  import rtc_trim_pkg::*;
#(
  parameter int unsigned STEP_W = 8
) (
  input  trim_t             trim_i,
  output logic              vld_o,
  output logic              neg_o,
  output logic [STEP_W-1:0] step_o
);

  logic [6:0] half_pos;
  logic [6:0] half_neg;

  assign half_pos = {1'b0, trim_i.mag} - 7'd1;
  assign half_neg = {1'b0, ~trim_i.mag} + 7'd1;

  assign vld_o  = |trim_i.mag[5:1];
  assign neg_o  = trim_i.neg;
  assign step_o = STEP_W'({(trim_i.neg ? half_neg : half_pos), 1'b0});

endmodule

// File: rtl/rtc_sec_div.sv
module rtc_sec_div #(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned SEC_TOP = 32767,
  parameter int unsigned STEP_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cnt_en_i,
  input  logic              trim_ld_i,
  input  logic              step_vld_i,
  input  logic              step_neg_i,
  input  logic [STEP_W-1:0] step_i,
  output logic              wrap_o
);

  localparam logic [CNT_W-1:0] TopV = CNT_W'(SEC_TOP);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] top_q;
  logic [CNT_W-1:0] step_ext;

  assign step_ext = CNT_W'(step_i);
  assign wrap_o   = cnt_en_i && (cnt_q == top_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      top_q <= TopV;
    end else if (wrap_o) begin
      if (trim_ld_i && step_vld_i && step_neg_i) begin
        cnt_q <= '0;
        top_q <= TopV + step_ext;
      end else if (trim_ld_i && step_vld_i) begin
        cnt_q <= step_ext;  // shortened second starts advanced
        top_q <= TopV;
      end else begin
        cnt_q <= '0;
        top_q <= TopV;
      end
    end else if (cnt_en_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/rtc_bcd_sec.sv
module rtc_bcd_sec
  import rtc_trim_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wrap_i,
  output logic [7:0] sec_o,
  output logic [7:0] sec_nxt_o,
  output logic       tick_o,
  output logic       carry_o
);

  logic [7:0] sec_q;
  logic       tick_q;
  logic       carry_q;

  assign sec_nxt_o = bcd_next(sec_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q   <= 8'h00;
      tick_q  <= 1'b0;
      carry_q <= 1'b0;
    end else begin
      tick_q  <= wrap_i;
      carry_q <= wrap_i && (sec_q == 8'h59);
      if (wrap_i) sec_q <= sec_nxt_o;
    end
  end

  assign sec_o   = sec_q;
  assign tick_o  = tick_q;
  assign carry_o = carry_q;

endmodule

// File: rtl/rtc_sec_trim.sv
module rtc_sec_trim
  import rtc_trim_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned SEC_TOP = 32767  // SEC_TOP + 124 must fit in CNT_W
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cnt_en_i,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  input  logic       rd_err_i,
  output logic [7:0] sec_bcd_o,
  output logic       sec_tick_o,
  output logic       min_carry_o,
  output logic [7:0] trim_reg_o,
  output logic       wr_err_o
);

  localparam int unsigned StepW = 8;

  trim_t            trim;
  logic             step_vld;
  logic             step_neg;
  logic [StepW-1:0] step;
  logic             wrap;
  logic [7:0]       sec_nxt;
  logic             trim_ld;

  rtc_trim_reg u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .rd_err_i  (rd_err_i),
    .sec_bcd_i (sec_bcd_o),
    .trim_o    (trim),
    .err_o     (wr_err_o)
  );

  rtc_trim_step #(.STEP_W(StepW)) u_step (
    .trim_i (trim),
    .vld_o  (step_vld),
    .neg_o  (step_neg),
    .step_o (step)
  );

  // trim taken at the tick that opens an eligible second
  assign trim_ld = is_trim_sec(trim.mode, sec_nxt);

  rtc_sec_div #(.CNT_W(CNT_W), .SEC_TOP(SEC_TOP), .STEP_W(StepW)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cnt_en_i   (cnt_en_i),
    .trim_ld_i  (trim_ld),
    .step_vld_i (step_vld),
    .step_neg_i (step_neg),
    .step_i     (step),
    .wrap_o     (wrap)
  );

  rtc_bcd_sec u_sec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wrap_i    (wrap),
    .sec_o     (sec_bcd_o),
    .sec_nxt_o (sec_nxt),
    .tick_o    (sec_tick_o),
    .carry_o   (min_carry_o)
  );

  assign trim_reg_o = trim;

endmodule

// File: rtl/rtc_sec_trim_chk.sv
module rtc_sec_trim_chk
  import rtc_trim_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cnt_en_i,
  input logic       wr_en_i,
  input logic [7:0] wr_data_i,
  input logic       rd_err_i,
  input logic [7:0] sec_bcd_o,
  input logic       sec_tick_o,
  input logic       min_carry_o,
  input logic [7:0] trim_reg_o,
  input logic       wr_err_o
);

  logic wr_blk;
  assign wr_blk = wr_en_i && is_trim_sec(trim_reg_o[7], sec_bcd_o);

  // R2
  idle_no_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_en_i |=> !sec_tick_o);

  // R2
  tick_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_tick_o |=> !sec_tick_o);

  // R3
  carry_with_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    min_carry_o |-> (sec_tick_o && sec_bcd_o == 8'h00));

  // R3
  sec_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sec_bcd_o) |-> sec_tick_o);

  // R3
  sec_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_bcd_o[7:4] <= 4'd5) && (sec_bcd_o[3:0] <= 4'd9));

  // R4
  wr_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_blk) |=> trim_reg_o == $past(wr_data_i));

  // R9
  wr_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_blk |=> ($stable(trim_reg_o) && wr_err_o));

  // R10
  err_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_err_i && !wr_blk) |=> !wr_err_o);

endmodule

bind rtc_sec_trim rtc_sec_trim_chk u_chk (.*);

// File: tb/rtc_sec_trim_bench.sv
`timescale 1ns/1ps
module rtc_sec_trim_bench;

  localparam int unsigned CW  = 9;
  localparam int unsigned TOP = 199;
  localparam int          NOM = TOP + 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cnt_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rd_err = 1'b0;
  logic [7:0] sec_bcd;
  logic       tick;
  logic       carry;
  logic [7:0] trim_reg;
  logic       wr_err;

  always #2 clk = ~clk;

  rtc_sec_trim #(.CNT_W(CW), .SEC_TOP(TOP)) u_rtc_sec_trim (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .cnt_en_i    (cnt_en),
    .wr_en_i     (wr_en),
    .wr_data_i   (wr_data),
    .rd_err_i    (rd_err),
    .sec_bcd_o   (sec_bcd),
    .sec_tick_o  (tick),
    .min_carry_o (carry),
    .trim_reg_o  (trim_reg),
    .wr_err_o    (wr_err)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int stride  = 1;
  int enc     = 0;
  int cyc     = 0;
  bit done    = 0;

  int         q_len[$];
  logic [7:0] q_sec[$];
  logic       q_car[$];
  string      q_tag[$];
  event       tick_ev;

  logic [7:0] reg_m = 8'h00;
  logic       err_m = 1'b0;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [7:0] to_bcd(input int s);
    return {4'(s / 10), 4'(s % 10)};
  endfunction

  function automatic bit elig(input logic mode, input int s);
    return mode ? (s == 0) : (s % 20 == 0);
  endfunction

  // monitor: one expected item per tick, length counted in enables
  always @(negedge clk) begin
    if (!rst_n) begin
      enc    = 0;
      cnt_en = 1'b0;
    end else begin
      if (carry && !tick) chk("R3", 32'(carry), 32'd0);
      if (tick) begin
        if (q_len.size() == 0) begin
          chk("R2", 32'd1, 32'd0);
        end else begin
          int         l;
          logic [7:0] s;
          logic       c;
          string      t;
          l = q_len.pop_front();
          s = q_sec.pop_front();
          c = q_car.pop_front();
          t = q_tag.pop_front();
          chk(t, 32'(enc), 32'(l));
          chk("R3", 32'(sec_bcd), 32'(s));
          chk("R3", 32'(carry), 32'(c));
        end
        enc = 0;
        -> tick_ev;
      end
      cyc++;
      cnt_en = ((cyc % stride) == 0);
      if (cnt_en) enc++;
    end
  end

  task automatic wr(input logic [7:0] d, input int s);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (elig(reg_m[7], s)) err_m = 1'b1;
    else reg_m = d;
    chk(elig(trim_reg_o_mode(), s) ? "R9" : "R4", 32'(trim_reg), 32'(reg_m));
    chk("R9", 32'(wr_err), 32'(err_m));
  endtask

  function automatic logic trim_reg_o_mode();
    return reg_m[7];
  endfunction

  task automatic rd();
    @(negedge clk);
    rd_err = 1'b1;
    @(negedge clk);
    rd_err = 1'b0;
    err_m  = 1'b0;
    chk("R10", 32'(wr_err), 32'd0);
  endtask

  task automatic push(input int m, input int s);
    int    len;
    int    f;
    int    st;
    string tag;
    f   = int'(reg_m[5:0]);
    len = NOM;
    tag = "R2";
    if (elig(reg_m[7], s)) begin
      if (f < 2) begin
        tag = "R8";
      end else if (reg_m[6]) begin
        st  = (64 - f) * 2;
        len = NOM + st;
        tag = "R7";
      end else begin
        st  = (f - 1) * 2;
        len = NOM - st;
        tag = "R6";
      end
    end else if (s % 20 == 0) begin
      tag = "R5";
    end
    if (m == 2 && s == 20) tag = "R11";
    q_len.push_back(len);
    q_sec.push_back(to_bcd((s + 1) % 60));
    q_car.push_back(s == 59);
    q_tag.push_back(tag);
  endtask

  initial begin
    int m;
    int s;
    repeat (3) @(negedge clk);
    // R1
    chk("R1", 32'(sec_bcd), 32'h00);
    chk("R1", 32'(trim_reg), 32'h00);
    chk("R1", 32'(tick), 32'd0);
    chk("R1", 32'(carry), 32'd0);
    chk("R1", 32'(wr_err), 32'd0);
    m = 0;
    s = 0;
    push(m, s);
    @(posedge clk);
    #1 rst_n = 1'b1;
    forever begin
      @(tick_ev);
      s = (s + 1) % 60;
      if (s == 0) m++;
      if (m == 3 && s == 3) break;
      push(m, s);
      if (m == 0 && s == 1)  wr(8'h05, s);  // +8, mode 0
      if (m == 0 && s == 20) begin
        wr(8'h7F, s);                        // refused
        rd();
      end
      if (m == 0 && s == 21) wr(8'h41, s);  // F[5:1] zero
      if (m == 0 && s == 41) wr(8'h7E, s);  // -4
      if (m == 1 && s == 1) begin
        stride = 2;
        wr(8'hC2, s);                        // mode 1, -124
      end
      if (m == 2 && s == 0)  wr(8'h01, s);  // refused in mode 1
      if (m == 2 && s == 20) begin
        wr(8'h3F, s);                        // mode 0, +124, mid-second
        rd();
      end
    end
    done = 1;
    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL R2 watchdog act=%0d exp=0", q_len.size());
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule